// File: doc/BRIEF.md
# Halt Wake-Up and Reset-Cause Controller

This block sits beside a small processor core. It owns the low-power halt state, decides which event ends it, and works out what the core does next. On a wake the core gets a full reset, or a warm reset that clears only the program counter and stack pointer, or a branch into the interrupt response, or it resumes at the next instruction. Every wake from halt, except an external reset, is followed by a fixed dummy stall before the core runs again.

Two status flags record the cause of the last reset. The timeout flag says the watchdog overflowed. The power-down flag says the core had gone into halt. After a reset, software reads both flags and tells power-up, external reset, watchdog timeout in run and watchdog wake from halt apart. The wake sources are an 8-bit input port, with a wake-enable mask bit for each port bit, an interrupt request, the watchdog overflow and the external reset pin. The port is synchronized by two flops before edge detection.

Top module: `haltWakeCtrl`

## Requirements
- R1: While the power-up reset `rstPowerN` is low and just after it is released, `toFlag`=0, `pdFlag`=0, `coreRun`=1, and all four outcome pulses are 0.
- R2: A `haltReq` in run, with no external reset and no watchdog overflow in the same cycle, drops `coreRun` in the next cycle. In that cycle `pdFlag`=1 and `toFlag`=0.
- R3: A `wdtClear` in run, with no halt request, watchdog overflow or external reset in the same cycle, clears both `toFlag` and `pdFlag` in the next cycle.
- R4: `extReset` gives a `fullResetPulse` in the next cycle. In run, both flags keep their values. While halted or in the dummy stall, the flags become `toFlag`=0 and `pdFlag`=1, and `coreRun` returns in that same next cycle. Each pulse lasts one cycle per sampled request.
- R5: A `wdtOverflow` in run, with no external reset, gives a one-cycle `fullResetPulse` and sets `toFlag`=1. `pdFlag` keeps its value and the core keeps running.
- R6: A `wdtOverflow` while halted, with no external reset, gives a one-cycle `warmResetPulse` and sets `toFlag`=1 and `pdFlag`=1. After the stall the core resumes with neither `takeIrq` nor `resumeNext`.
- R7: After the clock edge that accepts a wake from halt (any source except external reset), `coreRun` stays 0 for exactly `DUMMY_CYCLES` cycles. During that stall a watchdog overflow has no effect: it produces no pulse and does not change the stall length.
- R8: A falling edge on a port bit wakes the core only if that bit's `wakeMask` bit is 1. The edge is judged after the two-flop synchronizer, so the wake is accepted on the third rising edge after the pin changes. Edges on bits whose mask bit is 0 are ignored, and so is a bit that was already low when the halt began. A port wake ends with a one-cycle `resumeNext`.
- R9: An interrupt wake ends with `takeIrq` if `irqEnable`=1 and `stackFull`=0 at the wake. Otherwise it ends with `resumeNext`. The pulse lasts one cycle and falls in the first cycle that `coreRun` is 1 again.
- R10: An interrupt request that was already high when the halt was entered does not wake the core. Once the request has gone low during the halt, a new request wakes it.
- R11: While halted, wake sources that arrive in the same cycle are served in the order external reset, then watchdog overflow, then interrupt, then port edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPowerN | input | 1 | Asynchronous power-up reset, active low |
| extReset | input | 1 | External reset request, active high, sampled on the clock |
| haltReq | input | 1 | Core requests the halt state |
| wdtClear | input | 1 | Watchdog-clear strobe from the core |
| wdtOverflow | input | 1 | Watchdog overflow strobe |
| portIn | input | PORT_W | Input port pins, idle high |
| wakeMask | input | PORT_W | Per-bit wake enable for portIn |
| irqReq | input | 1 | Interrupt request flag |
| irqEnable | input | 1 | Interrupt enable |
| stackFull | input | 1 | Return stack is full |
| coreRun | output | 1 | Core may execute |
| fullResetPulse | output | 1 | One-cycle full core reset |
| warmResetPulse | output | 1 | One-cycle reset of program counter and stack pointer only |
| takeIrq | output | 1 | One-cycle: enter the interrupt response |
| resumeNext | output | 1 | One-cycle: continue at the next instruction |
| toFlag | output | 1 | Watchdog timeout status flag |
| pdFlag | output | 1 | Power-down (halt) status flag |

## Verification
A wrong state register shows up at `coreRun` within one cycle: the core runs when it should be halted, or stays stopped. A bad flag update shows on `toFlag` or `pdFlag` in the cycle after the event that caused it. A wrong stored wake kind stays hidden through the whole stall. It only appears, as the wrong outcome pulse, when the core resumes `DUMMY_CYCLES` cycles later, so the bench measures every stall to the exact cycle and checks the pulse at that point. A wrong port edge reference or a wrong interrupt-blocking bit shows as a missing wake or an extra wake, seen within a few cycles of the stimulus.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_DUMMY} hwcState_e;
  typedef enum logic [1:0] {WK_WARM, WK_NEXT, WK_IRQ} wakeKind_e;

  // Strobes sent from the control FSM to the datapath.
  typedef struct packed {
    logic captureCtx;   // halt entry: latch the pending-interrupt block
    logic toSet;
    logic toClr;
    logic pdSet;
    logic pdClr;
    logic cntRun;       // dummy-stall counter runs
  } hwcStrobe_t;
endpackage

// File: rtl/hwcDatapath.sv
module hwcDatapath
  import hwc_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter int DUMMY_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  input  logic              irqReq,
  input  hwcStrobe_t        strobe,
  output logic              portWake,
  output logic              irqWake,
  output logic              dummyDone,
  output logic              toFlag,
  output logic              pdFlag
);
  localparam int CNT_W = $clog2(DUMMY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DUMMY_CYCLES - 1);

  logic [PORT_W-1:0] syncA, syncB, portRef, fallBit;
  logic [CNT_W-1:0]  dummyCnt;
  logic              irqBlocked;

  // Two-flop synchronizer followed by a one-cycle reference for edge detection.
  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      syncA   <= '1;
      syncB   <= '1;
      portRef <= '1;
    end else begin
      syncA   <= portIn;
      syncB   <= syncA;
      portRef <= syncB;
    end
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_fall
    assign fallBit[b] = wakeMask[b] & portRef[b] & ~syncB[b];
  end
  assign portWake = |fallBit;

  // A request already high at halt entry stays blocked until it drops.
  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN)             irqBlocked <= 1'b0;
    else if (strobe.captureCtx) irqBlocked <= irqReq;
    else if (!irqReq)           irqBlocked <= 1'b0;
  end
  assign irqWake = irqReq & ~irqBlocked;

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN)         dummyCnt <= '0;
    else if (!strobe.cntRun) dummyCnt <= '0;
    else                    dummyCnt <= dummyCnt + 1'b1;
  end
  assign dummyDone = (dummyCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      toFlag <= 1'b0;
      pdFlag <= 1'b0;
    end else begin
      if (strobe.toSet)      toFlag <= 1'b1;
      else if (strobe.toClr) toFlag <= 1'b0;
      if (strobe.pdSet)      pdFlag <= 1'b1;
      else if (strobe.pdClr) pdFlag <= 1'b0;
    end
  end

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstPowerN)
    strobe.cntRun |-> dummyCnt < CNT_W'(DUMMY_CYCLES));
  a_r10_unblock: assert property (@(posedge clk) disable iff (!rstPowerN)
    !irqReq |=> !irqBlocked);
endmodule

// File: rtl/hwcControl.sv
module hwcControl
  import hwc_pkg::*;
(
  input  logic       clk,
  input  logic       rstPowerN,
  input  logic       extReset,
  input  logic       haltReq,
  input  logic       wdtClear,
  input  logic       wdtOverflow,
  input  logic       irqEnable,
  input  logic       stackFull,
  input  logic       portWake,
  input  logic       irqWake,
  input  logic       dummyDone,
  output hwcStrobe_t strobe,
  output logic       coreRun,
  output logic       fullResetPulse,
  output logic       warmResetPulse,
  output logic       takeIrq,
  output logic       resumeNext
);
  hwcState_e state, stateNext;
  wakeKind_e kind, kindNext;
  logic fullNext, warmNext, irqNext, nextNext;

  always_comb begin
    stateNext = state;
    kindNext  = kind;
    strobe    = '0;
    fullNext  = 1'b0;
    warmNext  = 1'b0;
    irqNext   = 1'b0;
    nextNext  = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (extReset) fullNext = 1'b1;
        else if (wdtOverflow) begin
          fullNext     = 1'b1;
          strobe.toSet = 1'b1;
        end else if (haltReq) begin
          stateNext         = ST_HALT;
          strobe.pdSet      = 1'b1;
          strobe.toClr      = 1'b1;
          strobe.captureCtx = 1'b1;
        end else if (wdtClear) begin
          strobe.toClr = 1'b1;
          strobe.pdClr = 1'b1;
        end
      end
      ST_HALT: begin
        if (extReset) begin
          stateNext    = ST_RUN;
          fullNext     = 1'b1;
          strobe.toClr = 1'b1;
          strobe.pdSet = 1'b1;
        end else if (wdtOverflow) begin
          stateNext    = ST_DUMMY;
          kindNext     = WK_WARM;
          warmNext     = 1'b1;
          strobe.toSet = 1'b1;
          strobe.pdSet = 1'b1;
        end else if (irqWake) begin
          stateNext = ST_DUMMY;
          kindNext  = (irqEnable && !stackFull) ? WK_IRQ : WK_NEXT;
        end else if (portWake) begin
          stateNext = ST_DUMMY;
          kindNext  = WK_NEXT;
        end
      end
      ST_DUMMY: begin
        strobe.cntRun = 1'b1;
        if (extReset) begin
          stateNext    = ST_RUN;
          fullNext     = 1'b1;
          strobe.toClr = 1'b1;
          strobe.pdSet = 1'b1;
        end else if (dummyDone) begin
          stateNext = ST_RUN;
          irqNext   = (kind == WK_IRQ);
          nextNext  = (kind == WK_NEXT);
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      state          <= ST_RUN;
      kind           <= WK_WARM;
      fullResetPulse <= 1'b0;
      warmResetPulse <= 1'b0;
      takeIrq        <= 1'b0;
      resumeNext     <= 1'b0;
    end else begin
      state          <= stateNext;
      kind           <= kindNext;
      fullResetPulse <= fullNext;
      warmResetPulse <= warmNext;
      takeIrq        <= irqNext;
      resumeNext     <= nextNext;
    end
  end

  assign coreRun = (state == ST_RUN);

  a_r9_after_dummy: assert property (@(posedge clk) disable iff (!rstPowerN)
    (takeIrq || resumeNext) |-> ($past(state) == ST_DUMMY) && coreRun);
  a_r6_warm_single: assert property (@(posedge clk) disable iff (!rstPowerN)
    warmResetPulse |=> !warmResetPulse);
  a_r4_full_cause: assert property (@(posedge clk) disable iff (!rstPowerN)
    fullResetPulse |-> $past(extReset || wdtOverflow));
endmodule

// File: rtl/haltWakeCtrl.sv
module haltWakeCtrl
  import hwc_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter int DUMMY_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              extReset,
  input  logic              haltReq,
  input  logic              wdtClear,
  input  logic              wdtOverflow,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  input  logic              irqReq,
  input  logic              irqEnable,
  input  logic              stackFull,
  output logic              coreRun,
  output logic              fullResetPulse,
  output logic              warmResetPulse,
  output logic              takeIrq,
  output logic              resumeNext,
  output logic              toFlag,
  output logic              pdFlag
);
  hwcStrobe_t strobe;
  logic portWake, irqWake, dummyDone;

  hwcControl u_ctrl (
    .clk, .rstPowerN, .extReset, .haltReq, .wdtClear, .wdtOverflow,
    .irqEnable, .stackFull, .portWake, .irqWake, .dummyDone,
    .strobe, .coreRun, .fullResetPulse, .warmResetPulse, .takeIrq, .resumeNext
  );

  hwcDatapath #(.PORT_W(PORT_W), .DUMMY_CYCLES(DUMMY_CYCLES)) u_dp (
    .clk, .rstPowerN, .portIn, .wakeMask, .irqReq, .strobe,
    .portWake, .irqWake, .dummyDone, .toFlag, .pdFlag
  );

  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rstPowerN)
    coreRun && haltReq && !extReset && !wdtOverflow |=> !coreRun && pdFlag && !toFlag);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rstPowerN)
    coreRun && wdtClear && !haltReq && !extReset && !wdtOverflow |=> !toFlag && !pdFlag);
  a_r5_wdt_run: assert property (@(posedge clk) disable iff (!rstPowerN)
    coreRun && wdtOverflow && !extReset |=> toFlag && fullResetPulse && coreRun);
  a_r6_warm_flags: assert property (@(posedge clk) disable iff (!rstPowerN)
    warmResetPulse |-> toFlag && pdFlag && !coreRun);
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rstPowerN)
    $onehot0({fullResetPulse, warmResetPulse, takeIrq, resumeNext}));
endmodule

// File: tb/test_haltWakeCtrl.sv
module test_haltWakeCtrl;
  localparam int N = 1024;
  logic clk = 1'b0;
  logic rstPowerN = 1'b0;
  logic extReset = 1'b0, haltReq = 1'b0, wdtClear = 1'b0, wdtOverflow = 1'b0;
  logic [7:0] portIn = 8'hFF, wakeMask = 8'h00;
  logic irqReq = 1'b0, irqEnable = 1'b0, stackFull = 1'b0;
  logic coreRun, fullResetPulse, warmResetPulse, takeIrq, resumeNext, toFlag, pdFlag;
  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;   // 50 MHz

  haltWakeCtrl #(.PORT_W(8), .DUMMY_CYCLES(N)) i_haltWakeCtrl (.*);

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic expTake(logic en, logic full);
    return en & ~full;
  endfunction

  task automatic doHalt();
    haltReq = 1'b1;
    tick();
    haltReq = 1'b0;
  endtask

  // Counts samples from the drive of a wake event until coreRun returns.
  task automatic countWake(output int n, output logic warm1, output logic extra);
    n = 0; warm1 = 1'b0; extra = 1'b0;
    do begin
      tick();
      n++;
      if (n == 1) begin
        warm1 = warmResetPulse;
        wdtOverflow = 1'b0;
        irqReq = 1'b0;
      end else if (fullResetPulse || warmResetPulse) extra = 1'b1;
      if (n == 5) begin wdtOverflow = 1'b1; portIn = 8'hFF; end
      if (n == 6) wdtOverflow = 1'b0;
    end while (!coreRun && n < N + 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    logic w1, ex;
    logic [7:0] m, bit1;
    logic en, full;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 toFlag in reset", toFlag, 0);
    chk("R1 pdFlag in reset", pdFlag, 0);
    rstPowerN = 1'b1;
    tick();
    chk("R1 toFlag", toFlag, 0);
    chk("R1 pdFlag", pdFlag, 0);
    chk("R1 coreRun", coreRun, 1);
    chk("R1 pulses", {fullResetPulse, warmResetPulse, takeIrq, resumeNext}, 0);

    // R5: watchdog overflow in run
    wdtOverflow = 1'b1; tick(); wdtOverflow = 1'b0;
    chk("R5 full pulse", fullResetPulse, 1);
    chk("R5 toFlag", toFlag, 1);
    chk("R5 pdFlag kept", pdFlag, 0);
    chk("R5 coreRun", coreRun, 1);
    tick();
    chk("R5 pulse one cycle", fullResetPulse, 0);

    // R2: halt entry
    doHalt();
    chk("R2 coreRun", coreRun, 0);
    chk("R2 pdFlag", pdFlag, 1);
    chk("R2 toFlag", toFlag, 0);

    // R4: external reset while halted
    extReset = 1'b1; tick(); extReset = 1'b0;
    chk("R4 full pulse halt", fullResetPulse, 1);
    chk("R4 coreRun", coreRun, 1);
    chk("R4 toFlag halt", toFlag, 0);
    chk("R4 pdFlag halt", pdFlag, 1);
    tick();
    chk("R4 pulse one cycle", fullResetPulse, 0);

    // R3: watchdog clear
    wdtClear = 1'b1; tick(); wdtClear = 1'b0;
    chk("R3 toFlag", toFlag, 0);
    chk("R3 pdFlag", pdFlag, 0);

    // R4: external reset in run keeps flags
    wdtOverflow = 1'b1; tick(); wdtOverflow = 1'b0; tick();
    extReset = 1'b1; tick(); extReset = 1'b0;
    chk("R4 full pulse run", fullResetPulse, 1);
    chk("R4 toFlag kept", toFlag, 1);
    chk("R4 pdFlag kept", pdFlag, 0);

    // R6/R7: watchdog wake from halt
    doHalt();
    wdtOverflow = 1'b1;
    countWake(n, w1, ex);
    chk("R6 warm pulse", w1, 1);
    chk("R7 stall length wdt", n, N + 1);
    chk("R7 wdt ignored in stall", ex, 0);
    chk("R6 no outcome", {takeIrq, resumeNext}, 0);
    chk("R6 toFlag", toFlag, 1);
    chk("R6 pdFlag", pdFlag, 1);

    // R8: directed port wake on bit 0
    wakeMask = 8'h01;
    doHalt();
    portIn[0] = 1'b0;
    countWake(n, w1, ex);
    chk("R8 port stall length", n, N + 3);
    chk("R8 resumeNext", resumeNext, 1);
    chk("R8 takeIrq", takeIrq, 0);
    tick();
    chk("R9 resumeNext one cycle", resumeNext, 0);

    // R8: level already low at halt entry is ignored
    portIn = 8'hFE;
    repeat (3) tick();
    doHalt();
    repeat (8) tick();
    chk("R8 low level ignored", coreRun, 0);
    extReset = 1'b1; tick(); extReset = 1'b0;
    portIn = 8'hFF; repeat (3) tick();

    // R8: random masks, unmasked edges ignored, then a masked edge wakes
    for (int i = 0; i < 4; i++) begin
      m = 8'($urandom);
      if (m == 8'h00) m = 8'h80;
      wakeMask = m;
      doHalt();
      portIn = 8'hFF ^ (~m & 8'($urandom));
      repeat (8) tick();
      chk("R8 unmasked ignored", coreRun, 0);
      bit1 = m & (~m + 8'd1);
      portIn = portIn & ~bit1;
      countWake(n, w1, ex);
      chk("R8 masked wake length", n, N + 3);
      chk("R8 masked resumeNext", resumeNext, 1);
      portIn = 8'hFF; repeat (3) tick();
    end
    wakeMask = 8'h00;

    // R9: random interrupt wakes
    for (int i = 0; i < 6; i++) begin
      en = 1'($urandom); full = 1'($urandom);
      if (i == 0) begin en = 1'b1; full = 1'b0; end
      if (i == 1) begin en = 1'b1; full = 1'b1; end
      irqEnable = en; stackFull = full;
      doHalt();
      irqReq = 1'b1;
      countWake(n, w1, ex);
      chk("R9 irq stall length", n, N + 1);
      chk("R9 takeIrq", takeIrq, expTake(en, full));
      chk("R9 resumeNext", resumeNext, !expTake(en, full));
    end

    // R10: request pending before halt cannot wake
    irqEnable = 1'b1; stackFull = 1'b0;
    irqReq = 1'b1; tick();
    doHalt();
    repeat (8) tick();
    chk("R10 pending blocked", coreRun, 0);
    irqReq = 1'b0; tick();
    irqReq = 1'b1;
    countWake(n, w1, ex);
    chk("R10 fresh request wakes", n, N + 1);
    chk("R10 takeIrq", takeIrq, 1);

    // R4: external reset during stall
    doHalt();
    irqReq = 1'b1; tick(); irqReq = 1'b0;
    repeat (4) tick();
    chk("R7 still stalled", coreRun, 0);
    extReset = 1'b1; tick(); extReset = 1'b0;
    chk("R4 full pulse stall", fullResetPulse, 1);
    chk("R4 coreRun after stall reset", coreRun, 1);
    chk("R4 flags after stall reset", {toFlag, pdFlag}, 1);

    // R11: priority external > watchdog > interrupt
    doHalt();
    extReset = 1'b1; wdtOverflow = 1'b1; irqReq = 1'b1;
    tick();
    extReset = 1'b0; wdtOverflow = 1'b0; irqReq = 1'b0;
    chk("R11 ext wins full", fullResetPulse, 1);
    chk("R11 ext wins warm", warmResetPulse, 0);
    chk("R11 ext wins run", coreRun, 1);
    tick();
    doHalt();
    wdtOverflow = 1'b1; irqReq = 1'b1;
    countWake(n, w1, ex);
    chk("R11 wdt over irq warm", w1, 1);
    chk("R11 wdt over irq outcome", {takeIrq, resumeNext}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule